// File: doc/BRIEF.md
# Dual-Edge GPIO and Multifunction Port

This block is the pin-control section of a card-socket buffer device. It owns two ports: a 13-pin general-purpose port and an 11-pin multifunction port. Each pin has an output value, an output-enable (direction) bit, a synchronized input level, separate enables for rising-edge and falling-edge detection, and separate sticky status bits for each edge kind. Software clears status by writing back ones. A single registered interrupt line reports any enabled status bit and is gated by a global enable in the control register.

Every multifunction pin has a select bit. When the bit is 0 the pin is an output that carries one line of an upper address bus (address bits 23 down to 13, pin 0 carrying bit 13). When the bit is 1 the pin is plain I/O. One extra select bit above the pins drives a video-enable flag. A simple synchronous register bus accesses all registers through 16-bit words. The host sees each word with its two bytes exchanged, unless a control bit selects native order.

Top module: `gpmf_port`

## Requirements
- R1: After reset every register is zero: general pins are all inputs with output value 0, every multifunction pin carries its upper-address line with output enable 1, video-enable is 0, the interrupt is 0 and read data is 0.
- R2: Registers sit at byte offsets 0x00 general out, 0x02 multi out, 0x04 general direction, 0x06 multi direction, 0x0A multi select, 0x0C general in, 0x0E multi in, 0x10/0x12 rising enables, 0x14/0x16 falling enables, 0x18/0x1A rising status, 0x1C/0x1E falling status, 0x20 control (general before multi in each pair). Bits above bit 12 (general) or bit 10 (multi; bit 11 of select excepted) read 0, and any other offset reads 0 and ignores writes. Read data appears one cycle after the read strobe.
- R3: With control bit 3 clear, the host word is the internal word with bytes exchanged in both directions. With bit 3 set, words pass unchanged. The control register keeps all 16 written bits.
- R4: Each general pin drives its output value when its direction bit is 1. Its output enable equals the direction bit.
- R5: A multifunction pin with select bit 0 outputs its upper-address line with output enable 1. With select bit 1 it behaves like a general pin. Select bit 11 drives video-enable.
- R6: The input registers return the pin level after a two-flop synchronizer, and writes to them have no effect.
- R7: A 0-to-1 change on a pin whose rising enable is 1 sets its rising status bit. A change with the enable at 0, or a 1-to-0 change, leaves the bit unchanged.
- R8: A 1-to-0 change on a pin whose falling enable is 1 sets its falling status bit and leaves the rising status alone.
- R9: Writing a status register clears each bit written as 1 and keeps each bit written as 0.
- R10: An edge that sets a status bit in the same cycle as a write that clears it leaves the bit set.
- R11: The interrupt, one cycle late, is the OR over both ports of rising status AND rising enable and falling status AND falling enable, ANDed with control bit 1. Clearing an enable masks the status bit without clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data in host byte order |
| bus_rdata | output | 16 | Read data in host byte order, valid the cycle after bus_rd |
| upper_addr | input | 11 | Upper address lines 23..13 for the multifunction pins |
| gp_in | input | 13 | General pin levels |
| gp_out | output | 13 | General pin output values |
| gp_oe | output | 13 | General pin output enables |
| mf_in | input | 11 | Multifunction pin levels |
| mf_out | output | 11 | Multifunction pin output values |
| mf_oe | output | 11 | Multifunction pin output enables |
| vid_en | output | 1 | Video-enable flag from select bit 11 |
| irq | output | 1 | Combined interrupt |

## Verification
A table of write/read-back pairs covers every offset with all-ones and mixed patterns. This separates masking of unimplemented bits, the byte exchange, and unmapped or read-only offsets. The edge tests drive multi-bit pin patterns where some changed pins are enabled for the opposite edge kind or not at all, so a status set by the wrong edge or without its enable shows as an extra bit. The select test uses all-zero, all-one and mixed select words against distinct address and output values, so every pin's source is seen. The clear-versus-edge test places the clear write in exactly the cycle the edge reaches the status register, which tells apart the two possible priorities.

// File: rtl/gpmf_pkg.sv
package gpmf_pkg;
  localparam int REG_W = 16;

  localparam int OFF_GP_DOUT  = 'h00;
  localparam int OFF_MF_DOUT  = 'h02;
  localparam int OFF_GP_DIR   = 'h04;
  localparam int OFF_MF_DIR   = 'h06;
  localparam int OFF_MF_SEL   = 'h0A;
  localparam int OFF_GP_DIN   = 'h0C;
  localparam int OFF_MF_DIN   = 'h0E;
  localparam int OFF_GP_REN   = 'h10;
  localparam int OFF_MF_REN   = 'h12;
  localparam int OFF_GP_FEN   = 'h14;
  localparam int OFF_MF_FEN   = 'h16;
  localparam int OFF_GP_RSTAT = 'h18;
  localparam int OFF_MF_RSTAT = 'h1A;
  localparam int OFF_GP_FSTAT = 'h1C;
  localparam int OFF_MF_FSTAT = 'h1E;
  localparam int OFF_CTRL     = 'h20;

  localparam int CTRL_GEN_BIT    = 1;
  localparam int CTRL_NATIVE_BIT = 3;

  typedef struct packed {
    logic dout;
    logic dir;
    logic ren;
    logic fen;
    logic rclr;
    logic fclr;
  } bank_we_t;

  function automatic logic [REG_W-1:0] swap_bytes(input logic [REG_W-1:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/gpmf_edge_sync.sv
module gpmf_edge_sync #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;
endmodule

// File: rtl/gpmf_bank.sv
module gpmf_bank
  import gpmf_pkg::*;
#(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  bank_we_t     we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dout_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] ren_o,
  output logic [W-1:0] fen_o,
  output logic [W-1:0] rst_o,
  output logic [W-1:0] fst_o,
  output logic [W-1:0] lvl_o,
  output logic         pend_o
);
  logic [W-1:0] rise_w, fall_w;
  logic [W-1:0] dout_q, dir_q, ren_q, fen_q, rst_q, fst_q;
  logic [W-1:0] dout_n, dir_n, ren_n, fen_n, rst_n_v, fst_n_v;
  logic [W-1:0] rclr_w, fclr_w;

  gpmf_edge_sync #(.W(W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .lvl_o  (lvl_o),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  always_comb begin
    dout_n = we_i.dout ? wdata_i : dout_q;
    dir_n  = we_i.dir  ? wdata_i : dir_q;
    ren_n  = we_i.ren  ? wdata_i : ren_q;
    fen_n  = we_i.fen  ? wdata_i : fen_q;
    rclr_w = we_i.rclr ? wdata_i : '0;
    fclr_w = we_i.fclr ? wdata_i : '0;
    // a new edge wins over a clear of the same bit
    rst_n_v = (rst_q & ~rclr_w) | (rise_w & ren_q);
    fst_n_v = (fst_q & ~fclr_w) | (fall_w & fen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      rst_q  <= '0;
      fst_q  <= '0;
    end else begin
      dout_q <= dout_n;
      dir_q  <= dir_n;
      ren_q  <= ren_n;
      fen_q  <= fen_n;
      rst_q  <= rst_n_v;
      fst_q  <= fst_n_v;
    end
  end

  assign dout_o = dout_q;
  assign dir_o  = dir_q;
  assign ren_o  = ren_q;
  assign fen_o  = fen_q;
  assign rst_o  = rst_q;
  assign fst_o  = fst_q;
  assign pend_o = |((rst_q & ren_q) | (fst_q & fen_q));
endmodule

// File: rtl/gpmf_port.sv
module gpmf_port
  import gpmf_pkg::*;
#(
  parameter int GP_W   = 13,
  parameter int MF_W   = 11,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [MF_W-1:0]   upper_addr,
  input  logic [GP_W-1:0]   gp_in,
  output logic [GP_W-1:0]   gp_out,
  output logic [GP_W-1:0]   gp_oe,
  input  logic [MF_W-1:0]   mf_in,
  output logic [MF_W-1:0]   mf_out,
  output logic [MF_W-1:0]   mf_oe,
  output logic              vid_en,
  output logic              irq
);
  localparam int SEL_W   = MF_W + 1;
  localparam int VID_BIT = MF_W;

  logic [REG_W-1:0] wd_int, rd_int;
  logic [REG_W-1:0] ctrl_q, ctrl_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic [REG_W-1:0] rdata_q, rdata_n;
  logic             irq_q, irq_n;
  logic             ctrl_native, ctrl_gen;
  bank_we_t         gp_we, mf_we;

  logic [GP_W-1:0] gp_dout, gp_dir, gp_ren, gp_fen, gp_rise_st, gp_fall_st, gp_lvl;
  logic [MF_W-1:0] mf_dout, mf_dir, mf_ren, mf_fen, mf_rise_st, mf_fall_st, mf_lvl;
  logic            gp_pend, mf_pend;
  logic [MF_W-1:0] mf_sel;

  assign ctrl_native = ctrl_q[CTRL_NATIVE_BIT];
  assign ctrl_gen    = ctrl_q[CTRL_GEN_BIT];
  assign mf_sel      = sel_q[MF_W-1:0];
  assign wd_int      = ctrl_native ? bus_wdata : swap_bytes(bus_wdata);

  // write strobe decode
  always_comb begin
    gp_we.dout = bus_wr && (bus_addr == ADDR_W'(OFF_GP_DOUT));
    gp_we.dir  = bus_wr && (bus_addr == ADDR_W'(OFF_GP_DIR));
    gp_we.ren  = bus_wr && (bus_addr == ADDR_W'(OFF_GP_REN));
    gp_we.fen  = bus_wr && (bus_addr == ADDR_W'(OFF_GP_FEN));
    gp_we.rclr = bus_wr && (bus_addr == ADDR_W'(OFF_GP_RSTAT));
    gp_we.fclr = bus_wr && (bus_addr == ADDR_W'(OFF_GP_FSTAT));
    mf_we.dout = bus_wr && (bus_addr == ADDR_W'(OFF_MF_DOUT));
    mf_we.dir  = bus_wr && (bus_addr == ADDR_W'(OFF_MF_DIR));
    mf_we.ren  = bus_wr && (bus_addr == ADDR_W'(OFF_MF_REN));
    mf_we.fen  = bus_wr && (bus_addr == ADDR_W'(OFF_MF_FEN));
    mf_we.rclr = bus_wr && (bus_addr == ADDR_W'(OFF_MF_RSTAT));
    mf_we.fclr = bus_wr && (bus_addr == ADDR_W'(OFF_MF_FSTAT));
  end

  gpmf_bank #(.W(GP_W)) u_gp (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (gp_in),
    .we_i    (gp_we),
    .wdata_i (wd_int[GP_W-1:0]),
    .dout_o  (gp_dout),
    .dir_o   (gp_dir),
    .ren_o   (gp_ren),
    .fen_o   (gp_fen),
    .rst_o   (gp_rise_st),
    .fst_o   (gp_fall_st),
    .lvl_o   (gp_lvl),
    .pend_o  (gp_pend)
  );

  gpmf_bank #(.W(MF_W)) u_mf (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (mf_in),
    .we_i    (mf_we),
    .wdata_i (wd_int[MF_W-1:0]),
    .dout_o  (mf_dout),
    .dir_o   (mf_dir),
    .ren_o   (mf_ren),
    .fen_o   (mf_fen),
    .rst_o   (mf_rise_st),
    .fst_o   (mf_fall_st),
    .lvl_o   (mf_lvl),
    .pend_o  (mf_pend)
  );

  // read mux, internal byte order
  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_GP_DOUT):  rd_int = REG_W'(gp_dout);
      ADDR_W'(OFF_MF_DOUT):  rd_int = REG_W'(mf_dout);
      ADDR_W'(OFF_GP_DIR):   rd_int = REG_W'(gp_dir);
      ADDR_W'(OFF_MF_DIR):   rd_int = REG_W'(mf_dir);
      ADDR_W'(OFF_MF_SEL):   rd_int = REG_W'(sel_q);
      ADDR_W'(OFF_GP_DIN):   rd_int = REG_W'(gp_lvl);
      ADDR_W'(OFF_MF_DIN):   rd_int = REG_W'(mf_lvl);
      ADDR_W'(OFF_GP_REN):   rd_int = REG_W'(gp_ren);
      ADDR_W'(OFF_MF_REN):   rd_int = REG_W'(mf_ren);
      ADDR_W'(OFF_GP_FEN):   rd_int = REG_W'(gp_fen);
      ADDR_W'(OFF_MF_FEN):   rd_int = REG_W'(mf_fen);
      ADDR_W'(OFF_GP_RSTAT): rd_int = REG_W'(gp_rise_st);
      ADDR_W'(OFF_MF_RSTAT): rd_int = REG_W'(mf_rise_st);
      ADDR_W'(OFF_GP_FSTAT): rd_int = REG_W'(gp_fall_st);
      ADDR_W'(OFF_MF_FSTAT): rd_int = REG_W'(mf_fall_st);
      ADDR_W'(OFF_CTRL):     rd_int = ctrl_q;
      default:               rd_int = '0;
    endcase
  end

  // next state of the top-level registers
  always_comb begin
    ctrl_n  = (bus_wr && (bus_addr == ADDR_W'(OFF_CTRL))) ? wd_int : ctrl_q;
    sel_n   = (bus_wr && (bus_addr == ADDR_W'(OFF_MF_SEL))) ? wd_int[SEL_W-1:0] : sel_q;
    rdata_n = bus_rd ? (ctrl_native ? rd_int : swap_bytes(rd_int)) : rdata_q;
    irq_n   = ctrl_gen & (gp_pend | mf_pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sel_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      sel_q   <= sel_n;
      rdata_q <= rdata_n;
      irq_q   <= irq_n;
    end
  end

  // pin drivers
  assign gp_out = gp_dout;
  assign gp_oe  = gp_dir;

  for (genvar i = 0; i < MF_W; i++) begin : g_mf_pin
    assign mf_out[i] = mf_sel[i] ? mf_dout[i] : upper_addr[i];
    assign mf_oe[i]  = mf_sel[i] ? mf_dir[i]  : 1'b1;
  end

  assign vid_en    = sel_q[VID_BIT];
  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/gpmf_port_chk.sv
module gpmf_port_chk
  import gpmf_pkg::*;
#(
  parameter int GP_W   = 13,
  parameter int MF_W   = 11,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [GP_W-1:0]   gp_rise_st,
  input logic [GP_W-1:0]   gp_ren,
  input logic [GP_W-1:0]   gp_lvl,
  input logic [MF_W-1:0]   mf_sel,
  input logic [MF_W-1:0]   mf_oe,
  input logic              ctrl_gen,
  input logic              gp_pend,
  input logic              mf_pend,
  input logic              irq
);
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && (bus_addr == ADDR_W'('h08))) |-> (bus_rdata == '0)); // R2

  AST_ADDR_MODE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mf_sel & ~mf_oe) == '0)); // R5

  AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((gp_rise_st & ~$past(gp_rise_st) & ~($past(gp_lvl) & $past(gp_ren))) == '0)); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(gp_rise_st) & ~gp_rise_st))
      |-> $past(bus_wr && (bus_addr == ADDR_W'(OFF_GP_RSTAT)))); // R9

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctrl_gen && (gp_pend || mf_pend))); // R11
endmodule

bind gpmf_port gpmf_port_chk #(.GP_W(GP_W), .MF_W(MF_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .gp_rise_st (gp_rise_st),
  .gp_ren     (gp_ren),
  .gp_lvl     (gp_lvl),
  .mf_sel     (mf_sel),
  .mf_oe      (mf_oe),
  .ctrl_gen   (ctrl_gen),
  .gp_pend    (gp_pend),
  .mf_pend    (mf_pend),
  .irq        (irq)
);

// File: tb/sim_gpmf_port.sv
module sim_gpmf_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [10:0] upper_addr = 11'h2A5;
  logic [12:0] gp_in = '0;
  logic [12:0] gp_out, gp_oe;
  logic [10:0] mf_in = '0;
  logic [10:0] mf_out, mf_oe;
  logic        vid_en, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpmf_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .upper_addr(upper_addr),
    .gp_in(gp_in), .gp_out(gp_out), .gp_oe(gp_oe), .mf_in(mf_in), .mf_out(mf_out),
    .mf_oe(mf_oe), .vid_en(vid_en), .irq(irq)
  );

  typedef struct packed {
    logic [5:0]  addr;
    logic [15:0] wdata;
    logic [15:0] exp;
  } vec_t;

  // host-order write, host-order expected read-back (R2, byte exchange active)
  localparam vec_t VECS [13] = '{
    '{6'h00, 16'hFFFF, 16'hFF1F},
    '{6'h02, 16'hFFFF, 16'hFF07},
    '{6'h04, 16'h3412, 16'h3412},
    '{6'h06, 16'h5A0F, 16'h5A07},
    '{6'h0A, 16'hFFFF, 16'hFF0F},
    '{6'h10, 16'hAA15, 16'hAA15},
    '{6'h12, 16'hFFFF, 16'hFF07},
    '{6'h14, 16'h0000, 16'h0000},
    '{6'h16, 16'h0100, 16'h0100},
    '{6'h08, 16'hFFFF, 16'h0000},
    '{6'h0C, 16'hFFFF, 16'h0000},
    '{6'h0E, 16'h1234, 16'h0000},
    '{6'h18, 16'hFFFF, 16'h0000}
  };

  function automatic logic [15:0] sw(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] r;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 gp_oe", 16'(gp_oe), 16'h0000);
    chk("R1 gp_out", 16'(gp_out), 16'h0000);
    chk("R1 mf_oe", 16'(mf_oe), 16'h07FF);
    chk("R1 mf_out", 16'(mf_out), 16'h02A5);
    chk("R1 vid_en", 16'(vid_en), 16'h0000);
    chk("R1 irq", 16'(irq), 16'h0000);
    chk("R1 rdata", bus_rdata, 16'h0000);

    // R2 table walk
    for (int i = 0; i < 13; i++) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rd(VECS[i].addr, r);
      chk($sformatf("R2 vec%0d", i), r, VECS[i].exp);
    end
    wr(6'h10, 16'h0000);
    wr(6'h12, 16'h0000);
    wr(6'h16, 16'h0000);

    // R4 general pin drive
    chk("R4 gp_out", 16'(gp_out), 16'h1FFF);
    chk("R4 gp_oe", 16'(gp_oe), 16'h1234);

    // R5 select modes
    chk("R5 all-io mf_out", 16'(mf_out), 16'h07FF);
    chk("R5 all-io mf_oe", 16'(mf_oe), 16'h075A);
    chk("R5 vid_en set", 16'(vid_en), 16'h0001);
    wr(6'h0A, 16'h0000);
    chk("R5 addr mf_out", 16'(mf_out), 16'h02A5);
    chk("R5 addr mf_oe", 16'(mf_oe), 16'h07FF);
    chk("R5 vid_en clr", 16'(vid_en), 16'h0000);
    wr(6'h0A, sw(16'h000F));
    chk("R5 mixed mf_out", 16'(mf_out), 16'h02AF);
    chk("R5 mixed mf_oe", 16'(mf_oe), 16'h07FA);

    // R3 native order
    wr(6'h20, 16'h0800);
    rd(6'h20, r); chk("R3 ctrl native", r, 16'h0008);
    rd(6'h04, r); chk("R3 dir native", r, 16'h1234);
    wr(6'h20, 16'h0000);
    rd(6'h20, r); chk("R3 ctrl cleared", r, 16'h0000);
    rd(6'h04, r); chk("R3 dir swapped", r, 16'h3412);

    // R6 synchronized inputs
    gp_in = 13'h0ABC; mf_in = 11'h555;
    idle(4);
    rd(6'h0C, r); chk("R6 gp din", r, sw(16'h0ABC));
    rd(6'h0E, r); chk("R6 mf din", r, sw(16'h0555));
    gp_in = '0; mf_in = '0;
    idle(4);
    wr(6'h18, 16'hFFFF); wr(6'h1A, 16'hFFFF); wr(6'h1C, 16'hFFFF); wr(6'h1E, 16'hFFFF);
    rd(6'h1C, r); chk("R7 no status without enable", r, 16'h0000);

    // R7 rising edges
    wr(6'h10, sw(16'h0021));
    wr(6'h14, sw(16'h0004));
    gp_in = 13'h00A5;
    idle(4);
    rd(6'h18, r); chk("R7 rising status", r, sw(16'h0021));
    rd(6'h1C, r); chk("R7 falling untouched", r, 16'h0000);

    // R8 falling edges
    gp_in = '0;
    idle(4);
    rd(6'h1C, r); chk("R8 falling status", r, sw(16'h0004));
    rd(6'h18, r); chk("R8 rising kept", r, sw(16'h0021));

    // R9 write-one-to-clear
    wr(6'h18, sw(16'h0001));
    rd(6'h18, r); chk("R9 partial clear", r, sw(16'h0020));
    wr(6'h1C, 16'h0000);
    rd(6'h1C, r); chk("R9 zero keeps", r, sw(16'h0004));

    // R11 interrupt
    idle(2);
    chk("R11 gated off", 16'(irq), 16'h0000);
    wr(6'h20, sw(16'h0002));
    idle(2);
    chk("R11 asserted", 16'(irq), 16'h0001);
    wr(6'h18, 16'hFFFF); wr(6'h1C, 16'hFFFF);
    idle(2);
    chk("R11 cleared", 16'(irq), 16'h0000);
    wr(6'h12, sw(16'h0008));
    mf_in = 11'h008;
    idle(5);
    chk("R11 mf source", 16'(irq), 16'h0001);
    rd(6'h1A, r); chk("R11 mf rising status", r, sw(16'h0008));
    wr(6'h12, 16'h0000);
    idle(2);
    chk("R11 masked", 16'(irq), 16'h0000);
    wr(6'h12, sw(16'h0008));
    idle(2);
    chk("R11 unmasked", 16'(irq), 16'h0001);
    wr(6'h20, 16'h0000);
    idle(2);
    chk("R11 global off", 16'(irq), 16'h0000);
    wr(6'h1A, 16'hFFFF);
    mf_in = '0;

    // R10 edge coinciding with clear
    gp_in = 13'h0001;
    idle(4);
    gp_in = 13'h0000;
    idle(4);
    rd(6'h18, r); chk("R10 setup set", r, sw(16'h0001));
    @(negedge clk);
    gp_in = 13'h0001;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 6'h18; bus_wdata = sw(16'h0001); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    idle(2);
    rd(6'h18, r); chk("R10 edge wins", r, sw(16'h0001));
    wr(6'h18, sw(16'h0001));
    rd(6'h18, r); chk("R10 later clear", r, 16'h0000);

    done = 1'b1;
    finish_run();
  end
endmodule